// File: doc/BRIEF.md
# Serial distributed-arithmetic FIR filter

This block is a short FIR filter. It forms the inner product of the last few input samples and a set of coefficients without using any multiplier. Each accepted sample goes into the newest slot of a bit-serial history. While an output is being computed, every history register rotates by a fixed number of bits per clock. In each cycle, one bit taken from every tap at the same bit position forms an address into a table. Each table entry holds the sum of the coefficients whose address bit is set. The value read from the table is weighted by its bit position and accumulated. The term for the sign bit is subtracted.

Coefficients are written at run time through an index/value port and held in staging registers. All table entries are rebuilt from the staged set in the cycle that accepts a sample. A write that arrives while a result is being computed therefore applies from the next sample on.

The number of sample bits handled per cycle is a parameter, `BPC`. Each extra bit per cycle adds a read port on the table. The cycles per result equal `DW/BPC`, whatever the number of taps.

The control is a three-state machine:
- `ST_IDLE` has ready high.
- `ST_IDLE` moves to `ST_RUN` when a strobe arrives.
- `ST_RUN` stays in `ST_RUN` while the slice counter advances.
- `ST_RUN` moves to `ST_DONE` on the last slice.
- `ST_DONE` moves to `ST_IDLE` after its single valid cycle.

Top module: `da_fir_serial`

## Requirements
- R1: While reset is asserted and right after it, `smp_ready` is 1, `res_valid` is 0 and `res_data` is 0. All staged coefficients and all history samples reset to zero.
- R2: A sample is accepted on a rising edge where both `smp_valid` and `smp_ready` are 1. From that edge until the edge that ends the valid cycle, `smp_ready` is 0. A strobe while `smp_ready` is 0 is ignored and changes neither the history nor any result.
- R3: `res_valid` is high for exactly one cycle. It rises on the `DW/BPC`-th rising edge after the accepting edge. `smp_ready` returns to 1 on the next edge. `BPC` must divide `DW`.
- R4: The result, read as a two's complement integer, equals the sum over tap k = 0..TAPS-1 of c[k]·x[k]. Here x[0] is the sample just accepted and x[k] is the sample accepted k samples earlier. Samples and coefficients are two's complement integers, and bit DW-1 of a sample carries negative weight.
- R5: Tap positions that have not yet received a sample since reset contribute zero. Each accepted sample moves every older sample one tap further back.
- R6: A write with `cw_en` = 1 stores `cw_data` as coefficient c[`cw_idx`], using the tap numbering of R4. A sample uses the coefficients staged as of its accepting cycle, including a write made in that same cycle. Writes during a computation affect only later samples.
- R7: `res_data` is `DW+CW+clog2(TAPS)` bits wide. It is exact for every combination of input values, including all samples and coefficients at their most negative value.
- R8: `res_data` changes only on the edge that raises `res_valid`, and it holds its value until the next such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_ready | output | 1 | Block can accept a sample this cycle |
| smp_data | input | DW | Two's complement sample |
| cw_en | input | 1 | Coefficient write enable |
| cw_idx | input | clog2(TAPS) | Tap number of the written coefficient |
| cw_data | input | CW | Two's complement coefficient value |
| res_valid | output | 1 | One-cycle pulse when a result is ready |
| res_data | output | DW+CW+clog2(TAPS) | Filter output, held between pulses |

## Verification
Two functions can meet in one cycle:
- **Coefficient write and sample acceptance.** A coefficient write can land in the same cycle that a sample is accepted, and so in the same cycle that the table is rebuilt. The bench provokes this by raising `cw_en` and `smp_valid` together at an idle cycle. The result of that sample must already reflect the new coefficient.
- **Write or strobe during a computation.** A write can also arrive in the middle of a computation, and a strobe can be held high through a busy period. In both cases the running result must be unchanged, and the write must show only in the next output.

The behavioural reference applies the write before the acceptance in each cycle. It is compared with ready, valid and the result on every clock.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } da_state_e;

endpackage

// File: rtl/da_skew_buffer.sv
// Sample history kept in bit-serial form. Tap 0 doubles as the
// parallel-to-serial register for the newest sample; older taps form the
// cascade. During a computation every tap rotates right by BPC bits per
// cycle, so after DW/BPC cycles all taps are back in place and the next
// load can shift them one tap further along.
module da_skew_buffer #(
    parameter int TAPS = 4,
    parameter int DW   = 8,
    parameter int BPC  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic [DW-1:0]        din,
    output logic [BPC*TAPS-1:0]  addr
);

    logic [TAPS*DW-1:0] hist;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        logic [DW-1:0] q;
        logic [DW-1:0] rot;
        logic [DW-1:0] src;

        if (BPC == DW) begin : g_full
            assign rot = q;
        end else begin : g_part
            assign rot = {q[BPC-1:0], q[DW-1:BPC]};
        end

        if (k == 0) begin : g_head
            assign src = din;
        end else begin : g_body
            assign src = hist[(k-1)*DW +: DW];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (load) begin
                q <= src;
            end else if (step) begin
                q <= rot;
            end
        end

        assign hist[k*DW +: DW] = q;

        // Slice j of the address takes bit j of every tap.
        for (genvar j = 0; j < BPC; j++) begin : g_bit
            assign addr[j*TAPS + k] = q[j];
        end
    end

endmodule

// File: rtl/da_coef_table.sv
// Staged coefficients and the table of coefficient sums. The table is a
// register file rebuilt in one cycle from the staged set (with a write in
// the same cycle merged in). It has one read port per bit handled per cycle.
module da_coef_table #(
    parameter int TAPS = 4,
    parameter int CW   = 8,
    parameter int BPC  = 1,
    localparam int IW  = $clog2(TAPS),
    localparam int TW  = CW + IW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [CW-1:0]       wr_data,
    input  logic                rebuild,
    input  logic [BPC*TAPS-1:0] addr,
    output logic [BPC*TW-1:0]   lut
);

    localparam int NENT = 1 << TAPS;

    logic [CW-1:0] coef_q [TAPS];
    logic [CW-1:0] coef_m [TAPS];
    logic [TW-1:0] tbl    [NENT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) begin
                coef_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < TAPS; k++) begin
                if (wr_en && (wr_idx == IW'(k))) begin
                    coef_q[k] <= wr_data;
                end
            end
        end
    end

    // Staged set with this cycle's write already applied.
    always_comb begin
        for (int k = 0; k < TAPS; k++) begin
            if (wr_en && (wr_idx == IW'(k))) begin
                coef_m[k] = wr_data;
            end else begin
                coef_m[k] = coef_q[k];
            end
        end
    end

    for (genvar a = 0; a < NENT; a++) begin : g_ent
        localparam logic [TAPS-1:0] SEL = TAPS'(a);
        logic [TW-1:0] sum;
        logic [TW-1:0] ent_q;

        always_comb begin
            sum = '0;
            for (int k = 0; k < TAPS; k++) begin
                if (SEL[k]) begin
                    sum = sum + {{IW{coef_m[k][CW-1]}}, coef_m[k]};
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (rebuild) begin
                ent_q <= sum;
            end
        end

        assign tbl[a] = ent_q;
    end

    for (genvar j = 0; j < BPC; j++) begin : g_port
        assign lut[j*TW +: TW] = tbl[addr[j*TAPS +: TAPS]];
    end

endmodule

// File: rtl/da_shift_acc.sv
// Position-weighted accumulation of the table outputs. Slice j of cycle p
// carries bit position p*BPC+j. The term for the last position (the sign
// bit) is subtracted.
module da_shift_acc #(
    parameter int DW   = 8,
    parameter int BPC  = 1,
    parameter int TW   = 10,
    parameter int AW   = 18,
    parameter int CNTW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              last,
    input  logic [CNTW-1:0]   pos,
    input  logic [BPC*TW-1:0] lut,
    output logic [AW-1:0]     res
);

    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] res_q;
    logic signed [AW-1:0] delta;
    logic signed [AW-1:0] term;

    always_comb begin
        delta = '0;
        term  = '0;
        for (int j = 0; j < BPC; j++) begin
            term = {{(AW-TW){lut[j*TW + TW - 1]}}, lut[j*TW +: TW]};
            term = term <<< (int'(pos) * BPC + j);
            if (last && (j == BPC - 1)) begin
                delta = delta - term;
            end else begin
                delta = delta + term;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            res_q <= '0;
        end else begin
            if (clear) begin
                acc_q <= '0;
            end else if (step) begin
                acc_q <= acc_q + delta;
            end
            if (last) begin
                res_q <= acc_q + delta;
            end
        end
    end

    assign res = res_q;

endmodule

// File: rtl/da_fir_serial.sv
module da_fir_serial
    import da_fir_pkg::*;
#(
    parameter int TAPS = 4,
    parameter int DW   = 8,
    parameter int CW   = 8,
    parameter int BPC  = 1,
    localparam int IW  = $clog2(TAPS),
    localparam int AW  = DW + CW + IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    output logic          smp_ready,
    input  logic [DW-1:0] smp_data,
    input  logic          cw_en,
    input  logic [IW-1:0] cw_idx,
    input  logic [CW-1:0] cw_data,
    output logic          res_valid,
    output logic [AW-1:0] res_data
);

    localparam int TW   = CW + IW;
    localparam int NC   = DW / BPC;
    localparam int CNTW = (NC > 1) ? $clog2(NC) : 1;

    da_state_e       state_q, state_nx;
    logic [CNTW-1:0] cnt_q;
    logic            accept;
    logic            step;
    logic            last;
    logic [BPC*TAPS-1:0] addr;
    logic [BPC*TW-1:0]   lut;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (smp_valid)                 state_nx = ST_RUN;
            ST_RUN:  if (cnt_q == CNTW'(NC - 1))    state_nx = ST_DONE;
            ST_DONE:                                state_nx = ST_IDLE;
            default:                                state_nx = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        smp_ready = (state_q == ST_IDLE);
        res_valid = (state_q == ST_DONE);
        accept    = smp_ready && smp_valid;
        step      = (state_q == ST_RUN);
        last      = step && (cnt_q == CNTW'(NC - 1));
    end

    // Slice counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    da_skew_buffer #(.TAPS(TAPS), .DW(DW), .BPC(BPC)) u_hist (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .step (step),
        .din  (smp_data),
        .addr (addr)
    );

    da_coef_table #(.TAPS(TAPS), .CW(CW), .BPC(BPC)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cw_en),
        .wr_idx (cw_idx),
        .wr_data(cw_data),
        .rebuild(accept),
        .addr   (addr),
        .lut    (lut)
    );

    da_shift_acc #(.DW(DW), .BPC(BPC), .TW(TW), .AW(AW), .CNTW(CNTW)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(accept),
        .step (step),
        .last (last),
        .pos  (cnt_q),
        .lut  (lut),
        .res  (res_data)
    );

endmodule

// File: rtl/da_fir_serial_chk.sv
module da_fir_serial_chk #(
    parameter int NC = 8,
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          smp_ready,
    input logic          res_valid,
    input logic [AW-1:0] res_data
);

    int unsigned since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= 0;
        end else if (smp_valid && smp_ready) begin
            since <= 1;
        end else if (res_valid) begin
            since <= 0;
        end else if (since != 0) begin
            since <= since + 1;
        end
    end

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);

    a_r2_no_ready_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !smp_ready);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (since == NC + 1));

    a_r3_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> smp_ready);

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data));

endmodule

bind da_fir_serial da_fir_serial_chk #(.NC(DW / BPC), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_ready(smp_ready),
    .res_valid(res_valid),
    .res_data (res_data)
);

// File: tb/da_fir_serial_test.sv
`timescale 1ns/1ps
module da_fir_serial_test;

    localparam int TAPS = 4;
    localparam int DW   = 8;
    localparam int CW   = 8;
    localparam int BPC  = 1;
    localparam int IW   = $clog2(TAPS);
    localparam int AW   = DW + CW + IW;
    localparam int NC   = DW / BPC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          cw_en = 1'b0;
    logic [IW-1:0] cw_idx = '0;
    logic [CW-1:0] cw_data = '0;
    logic          smp_ready;
    logic          res_valid;
    logic [AW-1:0] res_data;

    da_fir_serial #(.TAPS(TAPS), .DW(DW), .CW(CW), .BPC(BPC)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_ready(smp_ready),
        .smp_data (smp_data),
        .cw_en    (cw_en),
        .cw_idx   (cw_idx),
        .cw_data  (cw_data),
        .res_valid(res_valid),
        .res_data (res_data)
    );

    always #4 clk = ~clk;

    int     n_chk = 0;
    int     n_err = 0;
    string  cur_req = "R4";
    bit     live = 1'b0;

    // Behavioural reference
    int     m_coef [TAPS];
    int     m_hist [TAPS];
    int     m_cnt;
    longint m_pend;
    longint m_out;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_out = 0;
            m_pend = 0;
            for (int k = 0; k < TAPS; k++) begin
                m_coef[k] = 0;
                m_hist[k] = 0;
            end
        end else begin
            // R6: a write counts for a sample accepted in the same cycle
            if (cw_en) m_coef[cw_idx] = int'($signed(cw_data));
            if (m_cnt == 0 && smp_valid) begin
                for (int k = TAPS - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
                m_hist[0] = int'($signed(smp_data));
                m_pend = 0;
                for (int k = 0; k < TAPS; k++) m_pend += longint'(m_coef[k]) * m_hist[k];
                m_cnt = 1;
            end else if (m_cnt >= 1 && m_cnt <= NC) begin
                m_cnt++;
                if (m_cnt == NC + 1) m_out = m_pend;
            end else if (m_cnt == NC + 1) begin
                m_cnt = 0;
            end
        end
    end

    // Every-cycle comparison; the result check also covers the hold rule R8
    always @(negedge clk) begin
        if (live && rst_n) begin
            check(smp_ready == (m_cnt == 0), "R2", "ready", smp_ready, (m_cnt == 0));
            check(res_valid == (m_cnt == NC + 1), "R3", "valid", res_valid, (m_cnt == NC + 1));
            check(longint'($signed(res_data)) == m_out, cur_req, "result",
                  longint'($signed(res_data)), m_out);
        end
    end

    task automatic send(int v);
        @(negedge clk);
        while (!smp_ready) @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = DW'(v);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic wcoef(int idx, int v);
        @(negedge clk);
        cw_en   = 1'b1;
        cw_idx  = IW'(idx);
        cw_data = CW'(v);
        @(negedge clk);
        cw_en   = 1'b0;
    endtask

    task automatic send_and_write(int v, int idx, int c);
        @(negedge clk);
        while (!smp_ready) @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = DW'(v);
        cw_en     = 1'b1;
        cw_idx    = IW'(idx);
        cw_data   = CW'(c);
        @(negedge clk);
        smp_valid = 1'b0;
        cw_en     = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(smp_ready == 1'b1, "R1", "ready in reset", smp_ready, 1);
        check(res_valid == 1'b0, "R1", "valid in reset", res_valid, 0);
        check(res_data == '0, "R1", "result in reset", longint'($signed(res_data)), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(smp_ready == 1'b1, "R1", "ready after reset", smp_ready, 1);
        live = 1'b1;

        // R5: history fills from zero
        cur_req = "R5";
        wcoef(0, 1); wcoef(1, 2); wcoef(2, 3); wcoef(3, 4);
        send(10); send(20); send(-30); send(40); send(5);

        // R4: several patterns
        cur_req = "R4";
        wcoef(0, -7); wcoef(1, 13); wcoef(2, -100); wcoef(3, 55);
        for (int i = 0; i < 20; i++) send(int'($urandom_range(0, 255)));
        for (int i = 0; i < 6; i++) send(((i % 2) == 0) ? 1 : -1);

        // R2: strobe held high through busy periods with changing data
        cur_req = "R2";
        @(negedge clk);
        smp_valid = 1'b1;
        for (int i = 0; i < 60; i++) begin
            smp_data = DW'($urandom_range(0, 255));
            @(negedge clk);
        end
        smp_valid = 1'b0;

        // R6: writes during a computation and in the accepting cycle
        cur_req = "R6";
        send(33);
        wcoef(2, 77);
        wcoef(0, -90);
        send(-12);
        send_and_write(25, 1, -128);
        send_and_write(-64, 3, 127);
        send(0);

        // R7: extreme values
        cur_req = "R7";
        for (int k = 0; k < TAPS; k++) wcoef(k, -128);
        for (int i = 0; i < TAPS; i++) send(-128);
        for (int k = 0; k < TAPS; k++) wcoef(k, 127);
        for (int i = 0; i < TAPS; i++) send(-128);
        for (int i = 0; i < TAPS; i++) send(127);

        // R4: random samples with occasional coefficient changes
        cur_req = "R4";
        for (int i = 0; i < 40; i++) begin
            if ((i % 5) == 0) wcoef(int'($urandom_range(0, TAPS - 1)), int'($urandom_range(0, 255)));
            send(int'($urandom_range(0, 255)));
        end

        repeat (NC + 4) @(negedge clk);
        finish_run();
    end

endmodule